// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO with Programmable Flags

A single-clock FIFO for a parameterised number of words. A configuration input sampled while master reset is high picks one of two read-side modes. In standard mode a read request moves the oldest word into the output register. In first-word-fall-through (FWFT) mode the oldest word is placed in the output register without a request, and a read request consumes it. Two status outputs change meaning with the mode: in standard mode they report empty and full, and in FWFT mode they report output-ready and input-ready.

Three level outputs follow the stored word count. The stored word count is the number of words in the memory that have not yet been moved to the output register. Half-full compares the count with half the depth. Almost-empty and almost-full compare it against two offsets supplied on input ports, which may change at any time. A synchronous master reset clears the data path and loads the mode and the retransmit latency. A synchronous partial reset clears the data path and keeps the configuration. A retransmit rewinds only the read side to address zero, so the words written so far can be read again. This works as long as fewer than DEPTH words have been written since the last reset.

Top module: `dmfifo_top`

## Requirements
- R1: `cfgFwft` and `cfgZeroLatRetx` are captured only on clock edges where `masterRst` is high. They are kept unchanged through `partialRst` and through normal operation.
- R2: In standard mode, `emptyOrReady` is 1 exactly when the stored word count is 0 or a retransmit hold is in progress. `fullOrSpace` is 1 exactly when the count equals DEPTH. A clock edge with `rdEn` high and `emptyOrReady` low puts the oldest word on `rdData` right after that edge.
- R3: In FWFT mode, a word written into an empty FIFO appears on `rdData` with `emptyOrReady` = 1 one clock after the edge that wrote it, with no `rdEn`. An edge with `rdEn` high while `emptyOrReady` is 1 consumes that word. The next word is then presented at once, or `emptyOrReady` drops if no word remains.
- R4: In FWFT mode, `fullOrSpace` is 1 while the stored word count is below DEPTH. With the presented word, the FIFO then holds DEPTH+1 words.
- R5: A write is ignored when the stored count equals DEPTH. A standard-mode read is ignored while `emptyOrReady` is 1, and `rdData` keeps its value. A read and a write on the same edge, with neither limit reached, leave the count unchanged.
- R6: `almostEmpty` is 1 when the stored count is less than `emptyOffset`. It is 0 when the count is greater than or equal to `emptyOffset`. It follows a change of the offset without a clock edge.
- R7: `almostFull` is 1 when DEPTH minus the stored count is less than or equal to `fullOffset`, and 0 otherwise.
- R8: `halfFull` is 1 when the stored count is greater than DEPTH/2, and 0 otherwise.
- R9: After `masterRst` or `partialRst`, the read and write pointers are zero, the count is zero and `rdData` is all zeros. So in standard mode `emptyOrReady` = 1 and `fullOrSpace` = 0, and in FWFT mode `emptyOrReady` = 0 and `fullOrSpace` = 1.
- R10: A clock edge with `retransmit` high does the following:
  - sets the read pointer to 0 and the stored count to the write pointer, leaving the write side untouched;
  - forces standard-mode `emptyOrReady` to 1 for 1 cycle (zero latency) or 2 cycles (normal latency), during which reads are ignored;
  - drops FWFT-mode `emptyOrReady`.
- R11: In FWFT mode after a retransmit, the word at address 0 is loaded into `rdData` with `emptyOrReady` = 1. This happens on the first edge after the retransmit edge in zero-latency mode (`cfgZeroLatRetx` = 1), and on the second edge in normal-latency mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| masterRst | input | 1 | Synchronous reset; clears the data path and captures the configuration |
| partialRst | input | 1 | Synchronous reset; clears the data path and keeps the configuration |
| cfgFwft | input | 1 | 1 selects FWFT mode, 0 selects standard mode (captured at master reset) |
| cfgZeroLatRetx | input | 1 | 1 selects zero-latency retransmit, 0 selects normal latency (captured at master reset) |
| emptyOffset | input | CNT_W | Almost-empty threshold |
| fullOffset | input | CNT_W | Almost-full threshold in free locations |
| wrEn | input | 1 | Write request |
| wrData | input | DATA_W | Write data |
| rdEn | input | 1 | Read request (standard) or consume (FWFT) |
| retransmit | input | 1 | Rewind the read side to address 0 |
| rdData | output | DATA_W | Output register |
| emptyOrReady | output | 1 | Empty (standard) / output ready (FWFT) |
| fullOrSpace | output | 1 | Full (standard) / input ready (FWFT) |
| halfFull | output | 1 | Stored count above DEPTH/2 |
| almostEmpty | output | 1 | Stored count below `emptyOffset` |
| almostFull | output | 1 | Free locations at or below `fullOffset` |

## Verification
A wrong stored count shows up on the level flags on the same cycle, because they decode the count register with no further register. A broken pointer shows up as a wrong word on `rdData` at the first read that uses it. A mode bit corrupted by partial reset flips the meaning of `fullOrSpace` in the first cycle after that reset. A wrong retransmit hold length moves the reappearance of the address-0 word by one clock, so the checks sample the exact edge after the retransmit on which it must appear, and the edge before it.

// File: rtl/dmfifo_pkg.sv
package dmfifo_pkg;
  // Strobes from control to datapath, valid for one clock edge.
  typedef struct packed {
    logic clear;   // zero pointers and output register
    logic write;   // store wrData, advance write pointer
    logic load;    // move mem[rdPtr] into output register, advance read pointer
    logic rewind;  // read pointer back to address zero
  } dpStrobes_t;
endpackage

// File: rtl/dmfifo_datapath.sv
module dmfifo_datapath
  import dmfifo_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int DEPTH  = 64,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  dpStrobes_t        strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [ADDR_W-1:0] wrPtr,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] rdPtr;

  always_ff @(posedge clk) begin
    if (strb.write) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (strb.clear) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      rdData <= '0;
    end else begin
      if (strb.write) wrPtr <= wrPtr + 1'b1;
      if (strb.rewind) begin
        rdPtr <= '0;
      end else if (strb.load) begin
        rdData <= mem[rdPtr];
        rdPtr  <= rdPtr + 1'b1;
      end
    end
  end

  // R10: control never asks to rewind and load on the same edge
  assert_rewind_excl_R10: assert property (@(posedge clk) disable iff (strb.clear)
    strb.rewind |-> !strb.load);
endmodule

// File: rtl/dmfifo_ctrl.sv
module dmfifo_ctrl
  import dmfifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              masterRst,
  input  logic              partialRst,
  input  logic              cfgFwft,
  input  logic              cfgZeroLatRetx,
  input  logic [CNT_W-1:0]  emptyOffset,
  input  logic [CNT_W-1:0]  fullOffset,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              retransmit,
  input  logic [ADDR_W-1:0] wrPtr,
  output dpStrobes_t        strb,
  output logic              emptyOrReady,
  output logic              fullOrSpace,
  output logic              halfFull,
  output logic              almostEmpty,
  output logic              almostFull
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);

  logic             fwftMode, zeroLat;
  logic [CNT_W-1:0] count, baseCount;
  logic             outReady;
  logic [1:0]       retxWait;
  logic             clear, spaceAvail, stdEmpty;

  always_ff @(posedge clk) begin
    if (masterRst) begin
      fwftMode <= cfgFwft;
      zeroLat  <= cfgZeroLatRetx;
    end
  end

  always_comb begin
    clear      = masterRst || partialRst;
    spaceAvail = (count != FULL_CNT);
    stdEmpty   = (count == '0) || (retxWait != 2'd0);
    strb.clear  = clear;
    strb.write  = wrEn && spaceAvail && !clear;
    strb.rewind = retransmit && !clear;
    if (fwftMode)
      strb.load = !clear && !retransmit && (count != '0) && (retxWait <= 2'd1) &&
                  (!outReady || rdEn);
    else
      strb.load = !clear && !retransmit && rdEn && !stdEmpty;
    baseCount = retransmit ? CNT_W'(wrPtr) : count;
  end

  always_ff @(posedge clk) begin
    if (clear) begin
      count    <= '0;
      outReady <= 1'b0;
      retxWait <= 2'd0;
    end else begin
      count <= baseCount + CNT_W'(strb.write) - CNT_W'(strb.load);
      if (retransmit)                outReady <= 1'b0;
      else if (strb.load && fwftMode) outReady <= 1'b1;
      else if (rdEn && outReady)      outReady <= 1'b0;
      if (retransmit)                retxWait <= zeroLat ? 2'd1 : 2'd2;
      else if (retxWait != 2'd0)     retxWait <= retxWait - 2'd1;
    end
  end

  always_comb begin
    emptyOrReady = fwftMode ? outReady : stdEmpty;
    fullOrSpace  = fwftMode ? spaceAvail : !spaceAvail;
    halfFull     = count > HALF_CNT;
    almostEmpty  = count < emptyOffset;
    almostFull   = (FULL_CNT - count) <= fullOffset;
  end

  // R5: the stored count never passes the depth
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (masterRst)
    count <= FULL_CNT);
  // R10: the cycle after a retransmit reports no readable word
  assert_retx_flag_R10: assert property (@(posedge clk) disable iff (masterRst || partialRst)
    retransmit |=> (fwftMode ? !outReady : emptyOrReady));
  // R3: output-ready only rises in FWFT mode from a non-empty memory
  assert_fwft_ready_R3: assert property (@(posedge clk) disable iff (masterRst || partialRst)
    $rose(outReady) |-> (fwftMode && $past(count) != '0));
  // R1: partial reset leaves the mode alone
  assert_mode_hold_R1: assert property (@(posedge clk) disable iff (masterRst)
    partialRst |=> $stable(fwftMode));
endmodule

// File: rtl/dmfifo_top.sv
module dmfifo_top
  import dmfifo_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int DEPTH  = 64,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              masterRst,
  input  logic              partialRst,
  input  logic              cfgFwft,
  input  logic              cfgZeroLatRetx,
  input  logic [CNT_W-1:0]  emptyOffset,
  input  logic [CNT_W-1:0]  fullOffset,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic              retransmit,
  output logic [DATA_W-1:0] rdData,
  output logic              emptyOrReady,
  output logic              fullOrSpace,
  output logic              halfFull,
  output logic              almostEmpty,
  output logic              almostFull
);
  dpStrobes_t        strb;
  logic [ADDR_W-1:0] wrPtr;

  dmfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk, .masterRst, .partialRst, .cfgFwft, .cfgZeroLatRetx,
    .emptyOffset, .fullOffset, .wrEn, .rdEn, .retransmit, .wrPtr,
    .strb, .emptyOrReady, .fullOrSpace, .halfFull, .almostEmpty, .almostFull
  );

  dmfifo_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk, .strb, .wrData, .wrPtr, .rdData
  );
endmodule

// File: tb/test_dmfifo_top.sv
module test_dmfifo_top;
  localparam int DATA_W = 36;
  localparam int DEPTH  = 8;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic masterRst = 1'b1, partialRst = 1'b0, cfgFwft = 1'b0, cfgZeroLatRetx = 1'b1;
  logic [CNT_W-1:0] emptyOffset = CNT_W'(2), fullOffset = CNT_W'(2);
  logic wrEn = 1'b0, rdEn = 1'b0, retransmit = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic emptyOrReady, fullOrSpace, halfFull, almostEmpty, almostFull;
  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dmfifo_top #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_dmfifo_top (.*);

  typedef struct packed {
    logic wr; logic rd; logic [7:0] din; logic [3:0] cnt; logic [7:0] q;
  } vec_t;
  // standard mode walk, offsets 2/2, depth 8: expected count and rdData
  localparam int NVEC = 22;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1,1'b0,8'h11,4'd1,8'h00}, '{1'b1,1'b0,8'h22,4'd2,8'h00},
    '{1'b0,1'b1,8'h00,4'd1,8'h11}, '{1'b1,1'b1,8'h33,4'd1,8'h22},
    '{1'b1,1'b0,8'h44,4'd2,8'h22}, '{1'b1,1'b0,8'h55,4'd3,8'h22},
    '{1'b1,1'b0,8'h66,4'd4,8'h22}, '{1'b1,1'b0,8'h77,4'd5,8'h22},
    '{1'b1,1'b0,8'h88,4'd6,8'h22}, '{1'b1,1'b0,8'h99,4'd7,8'h22},
    '{1'b1,1'b0,8'hAA,4'd8,8'h22}, '{1'b1,1'b0,8'hBB,4'd8,8'h22},
    '{1'b0,1'b1,8'h00,4'd7,8'h33}, '{1'b1,1'b1,8'hCC,4'd7,8'h44},
    '{1'b0,1'b1,8'h00,4'd6,8'h55}, '{1'b0,1'b1,8'h00,4'd5,8'h66},
    '{1'b0,1'b1,8'h00,4'd4,8'h77}, '{1'b0,1'b1,8'h00,4'd3,8'h88},
    '{1'b0,1'b1,8'h00,4'd2,8'h99}, '{1'b0,1'b1,8'h00,4'd1,8'hAA},
    '{1'b0,1'b1,8'h00,4'd0,8'hCC}, '{1'b0,1'b1,8'h00,4'd0,8'hCC}
  };

  task automatic cyc();
    @(posedge clk); #2;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doMasterReset(input logic fwft, input logic zl);
    masterRst = 1'b1; cfgFwft = fwft; cfgZeroLatRetx = zl;
    wrEn = 1'b0; rdEn = 1'b0; retransmit = 1'b0; partialRst = 1'b0;
    emptyOffset = CNT_W'(2); fullOffset = CNT_W'(2);
    cyc(); cyc();
    masterRst = 1'b0;
  endtask

  task automatic writeWord(input logic [DATA_W-1:0] d);
    wrEn = 1'b1; wrData = d; cyc(); wrEn = 1'b0;
  endtask

  // FWFT retransmit latency check, zl selects latency (R11)
  task automatic fwftRetx(input logic zl);
    doMasterReset(1'b1, zl);
    writeWord(36'hA1); writeWord(36'hB2); writeWord(36'hC3); cyc();
    chk("R3 first word shown", rdData, 36'hA1);
    rdEn = 1'b1; cyc(); rdEn = 1'b0;
    chk("R3 consume", rdData, 36'hB2);
    retransmit = 1'b1; cyc(); retransmit = 1'b0;
    chk("R10 fwft ready dropped", emptyOrReady, 1'b0);
    cyc();
    if (zl) begin
      chk("R11 zero latency ready", emptyOrReady, 1'b1);
      chk("R11 zero latency data", rdData, 36'hA1);
    end else begin
      chk("R11 normal latency not yet", emptyOrReady, 1'b0);
      cyc();
      chk("R11 normal latency ready", emptyOrReady, 1'b1);
      chk("R11 normal latency data", rdData, 36'hA1);
    end
  endtask

  initial begin
    doMasterReset(1'b0, 1'b1);
    cyc();
    // R9 reset state in standard mode
    chk("R9 empty", emptyOrReady, 1'b1);
    chk("R9 full", fullOrSpace, 1'b0);
    chk("R9 rdData", rdData, '0);
    chk("R9 almostEmpty", almostEmpty, 1'b1);
    chk("R9 almostFull", almostFull, 1'b0);
    chk("R9 halfFull", halfFull, 1'b0);

    // Table walk: R2, R5 (ignored write at step 12, ignored read at step 22,
    // simultaneous read/write at steps 4 and 14), R6, R7, R8
    for (int i = 0; i < NVEC; i++) begin
      wrEn = VEC[i].wr; rdEn = VEC[i].rd; wrData = DATA_W'(VEC[i].din);
      cyc();
      chk("R2 empty", emptyOrReady, VEC[i].cnt == 0);
      chk("R2 full", fullOrSpace, VEC[i].cnt == DEPTH);
      chk("R2/R5 rdData", rdData, DATA_W'(VEC[i].q));
      chk("R6 almostEmpty", almostEmpty, VEC[i].cnt < 2);
      chk("R7 almostFull", almostFull, (DEPTH - VEC[i].cnt) <= 2);
      chk("R8 halfFull", halfFull, VEC[i].cnt > DEPTH / 2);
    end
    wrEn = 1'b0; rdEn = 1'b0;

    // FWFT fill to capacity DEPTH+1 (R3, R4, R5)
    doMasterReset(1'b1, 1'b1);
    cyc();
    chk("R9 fwft not ready", emptyOrReady, 1'b0);
    chk("R9 fwft has space", fullOrSpace, 1'b1);
    wrEn = 1'b1; wrData = 36'h100; cyc(); wrEn = 1'b0;
    chk("R3 ready not yet", emptyOrReady, 1'b0);
    wrEn = 1'b1;
    for (int i = 1; i <= DEPTH; i++) begin
      wrData = 36'h100 + DATA_W'(i); cyc();
      if (i == 1) chk("R3 ready one clock later", emptyOrReady, 1'b1);
    end
    wrData = 36'h1FF; cyc(); wrEn = 1'b0;   // ignored write
    chk("R4 no space", fullOrSpace, 1'b0);
    chk("R7 fwft almostFull", almostFull, 1'b1);
    for (int i = 0; i <= DEPTH; i++) begin
      chk("R3 fwft order", rdData, 36'h100 + DATA_W'(i));
      chk("R3 fwft ready", emptyOrReady, 1'b1);
      rdEn = 1'b1; cyc(); rdEn = 1'b0;
    end
    chk("R5 full write ignored", emptyOrReady, 1'b0);

    // Partial reset keeps FWFT mode even though cfgFwft changes (R1, R9)
    writeWord(36'h77); cyc();
    cfgFwft = 1'b0; partialRst = 1'b1; cyc(); partialRst = 1'b0;
    chk("R9 partial rdData", rdData, '0);
    chk("R9 partial not ready", emptyOrReady, 1'b0);
    chk("R1 mode kept", fullOrSpace, 1'b1);
    writeWord(36'h5A); cyc();
    chk("R1 still fall-through", rdData, 36'h5A);

    fwftRetx(1'b1);
    fwftRetx(1'b0);

    // Standard retransmit, zero latency (R10, R6, R7 runtime offsets)
    doMasterReset(1'b0, 1'b1);
    writeWord(36'hA1); writeWord(36'hB2); writeWord(36'hC3);
    rdEn = 1'b1; cyc(); cyc(); rdEn = 1'b0;
    chk("R2 second read", rdData, 36'hB2);
    retransmit = 1'b1; cyc(); retransmit = 1'b0;
    chk("R10 empty forced", emptyOrReady, 1'b1);
    cyc();
    chk("R10 hold ended", emptyOrReady, 1'b0);
    chk("R10 count rewound", almostEmpty, 1'b0);
    emptyOffset = CNT_W'(4); fullOffset = CNT_W'(5); #1;
    chk("R6 runtime offset", almostEmpty, 1'b1);
    chk("R7 runtime offset", almostFull, 1'b1);
    rdEn = 1'b1; cyc(); rdEn = 1'b0;
    chk("R10 reread word0", rdData, 36'hA1);

    // Standard retransmit, normal latency: reads ignored during hold (R10)
    doMasterReset(1'b0, 1'b0);
    writeWord(36'hA1); writeWord(36'hB2); writeWord(36'hC3);
    rdEn = 1'b1; cyc(); cyc(); rdEn = 1'b0;
    retransmit = 1'b1; cyc(); retransmit = 1'b0;
    rdEn = 1'b1; cyc();
    chk("R10 hold cycle 1", emptyOrReady, 1'b1);
    chk("R10 read ignored 1", rdData, 36'hB2);
    cyc();
    chk("R10 hold over", emptyOrReady, 1'b0);
    chk("R10 read ignored 2", rdData, 36'hB2);
    cyc(); rdEn = 1'b0;
    chk("R10 normal reread", rdData, 36'hA1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule